// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This unit sits between a processor core and a data memory that is one 32-bit word wide. For each request it adds a sign-extended 16-bit displacement to a base register value to form the effective address. It checks that address against the access size, and it presents a word-aligned memory address one clock later. The request's store/load kind, size and signedness select the lanes that are used.

Lanes follow big-endian order: the byte at the lowest address of a word is its most significant byte. On a store the unit places the low bits of the source register on the addressed lanes and raises only the matching byte enables. On a load it takes the addressed lane out of the word that memory returns and sign- or zero-extends it to 32 bits. A misaligned request writes nothing, starts no read and raises a fault flag for one cycle.

Top module: `be_lsu`

## Requirements
- R1: The effective address is `base + sext(disp)`, where the 16-bit displacement is sign-extended to 32 bits. One cycle after a request, `mem_addr` holds that address with bits 1:0 cleared.
- R2: `req_size` encodes the access size: 0 is a byte, 1 is a halfword, and 2 or 3 is a word. A halfword is misaligned when address bit 0 is 1. A word is misaligned when address bits 1:0 are nonzero. A byte is never misaligned.
- R3: A misaligned request raises `misalign` for exactly the one cycle after the request. In that cycle `mem_be` is 0 and `mem_wr`, `mem_rd` and `ld_valid` are all low.
- R4: An aligned store asserts `mem_wr`. `mem_be[3]` covers data bits 31:24 (offset 0) and `mem_be[0]` covers bits 7:0 (offset 3). A byte at offset k enables only bit 3-k. A halfword at offset 0 gives 4'b1100 and at offset 2 gives 4'b0011. A word gives 4'b1111.
- R5: On a store, the byte lanes enabled by `mem_be` carry the low byte, the low halfword or the whole source word of `st_src`, placed in big-endian order. Merging them into the memory word changes only the addressed bytes.
- R6: On an aligned load the cycle after the request, `ld_data` is taken from `mem_rdata`. A byte at offset k comes from bits [31-8k -: 8]. A halfword at offset k comes from bits [31-8k -: 16]. A word is the whole of `mem_rdata`.
- R7: Sub-word loads sign-extend when `req_unsigned` is 0 and zero-extend when it is 1. `req_unsigned` has no effect on word loads.
- R8: While `rst_n` is low, every output is 0.
- R9: A cycle with no request is followed by a cycle with `mem_wr`, `mem_rd`, `ld_valid` and `misalign` low, `mem_be` equal to 0 and `ld_data` equal to 0.
- R10: Loads never raise byte enables or `mem_wr`. Stores never raise `mem_rd` or `ld_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_unsigned | input | 1 | Zero-extend sub-word loads |
| base | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| st_src | input | 32 | Store source register |
| mem_rdata | input | 32 | Memory read word for the request issued last cycle |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_rd | output | 1 | Aligned load issued |
| mem_wr | output | 1 | Aligned store issued |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Store data on the byte lanes |
| misalign | output | 1 | Misaligned request fault |
| ld_valid | output | 1 | `ld_data` is valid |
| ld_data | output | 32 | Extended load result |

## Verification
A wrong lane offset or size held in the request register shows up one cycle after the request. It appears as a byte-enable pattern that does not match the address, or as a merged memory word in which some other byte changed. On loads it shows in the same cycle as a result taken from the wrong lane or extended with the wrong sign. A stale alignment decision shows as a fault with enables still raised, or as a write that goes ahead on a misaligned address. The bench tries every offset with every size, direction and signedness, using displacements of both signs, so each such error surfaces within one request.

// File: rtl/be_lsu.sv
module be_lsu #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_store,
  input  logic [1:0]    req_size,
  input  logic          req_unsigned,
  input  logic [AW-1:0] base,
  input  logic [15:0]   disp,
  input  logic [DW-1:0] st_src,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [3:0]    mem_be,
  output logic [DW-1:0] mem_wdata,
  output logic          misalign,
  output logic          ld_valid,
  output logic [DW-1:0] ld_data
);
  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;

  logic [AW-1:0] ea;
  logic [1:0]    off;
  logic          is_b, is_h, is_w, bad;
  logic [3:0]    be_n;
  logic [DW-1:0] wd_n;

  assign ea   = base + {{(AW-16){disp[15]}}, disp};
  assign off  = ea[1:0];
  assign is_b = (req_size == SZ_B);
  assign is_h = (req_size == SZ_H);
  assign is_w = req_size[1];
  assign bad  = (is_h & off[0]) | (is_w & (off != 2'b00));

  always_comb begin
    if (is_b)      be_n = 4'b1000 >> off;
    else if (is_h) be_n = off[1] ? 4'b0011 : 4'b1100;
    else           be_n = 4'b1111;
  end

  always_comb begin
    if (is_b)      wd_n = {4{st_src[7:0]}};
    else if (is_h) wd_n = {2{st_src[15:0]}};
    else           wd_n = st_src;
  end

  logic [1:0] q_off, q_size;
  logic       q_uns;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_be    <= 4'b0;
      mem_wdata <= '0;
      misalign  <= 1'b0;
      ld_valid  <= 1'b0;
      q_off     <= 2'b0;
      q_size    <= 2'b0;
      q_uns     <= 1'b0;
    end else begin
      mem_addr  <= {ea[AW-1:2], 2'b00};
      mem_rd    <= req_valid & ~req_store & ~bad;
      mem_wr    <= req_valid &  req_store & ~bad;
      mem_be    <= (req_valid & req_store & ~bad) ? be_n : 4'b0;
      mem_wdata <= (req_valid & req_store & ~bad) ? wd_n : '0;
      misalign  <= req_valid & bad;
      ld_valid  <= req_valid & ~req_store & ~bad;
      q_off     <= off;
      q_size    <= req_size;
      q_uns     <= req_unsigned;
    end
  end

  logic [1:0]    lane;
  logic [DW-1:0] rsh;

  assign lane = (q_size == SZ_B) ? ~q_off : {~q_off[1], 1'b0};
  assign rsh  = mem_rdata >> {lane, 3'b000};

  always_comb begin
    if (!ld_valid)            ld_data = '0;
    else if (q_size == SZ_B)  ld_data = {{(DW-8){~q_uns & rsh[7]}}, rsh[7:0]};
    else if (q_size == SZ_H)  ld_data = {{(DW-16){~q_uns & rsh[15]}}, rsh[15:0]};
    else                      ld_data = mem_rdata;
  end
endmodule

module be_lsu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_store,
  input logic [31:0] mem_addr,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [3:0]  mem_be,
  input logic        misalign,
  input logic        ld_valid
);
  a_r3_fault_blocks_access: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (mem_be == 4'b0 && !mem_wr && !mem_rd && !ld_valid));
  a_r3_fault_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> $past(req_valid));
  a_r4_enable_count: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($countones(mem_be) == 1 || mem_be == 4'b1100 || mem_be == 4'b0011 || mem_be == 4'b1111));
  a_r10_store_origin: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(req_valid && req_store));
  a_r10_load_origin: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> $past(req_valid && !req_store));
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr) && !(ld_valid && mem_be != 4'b0));
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!mem_wr && !mem_rd && !misalign && mem_be == 4'b0));
  a_r1_word_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr[1:0] == 2'b00);
endmodule

bind be_lsu be_lsu_chk chk (.*);

// File: tb/be_lsu_test.sv
module be_lsu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] base = '0, st_src = '0, mem_rdata = '0;
  logic [15:0] disp = '0;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic        mem_rd, mem_wr, misalign, ld_valid;
  logic [3:0]  mem_be;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  be_lsu uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] w, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] m = w;
    for (int i = 0; i < 4; i++) if (be[i]) m[8*i +: 8] = d[8*i +: 8];
    return m;
  endfunction

  task automatic req(input logic st, input logic [1:0] sz, input logic uns,
                     input logic [31:0] b, input logic [15:0] d, input logic [31:0] src);
    req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = uns;
    base = b; disp = d; st_src = src;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 be", {28'b0, mem_be}, 0);
    chk("R8 flags", {28'b0, mem_rd, mem_wr, misalign, ld_valid}, 0);
    chk("R8 addr", mem_addr, 0);
    chk("R8 ld_data", ld_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int di = 0; di < 2; di++)
      for (int sz = 0; sz < 4; sz++)
        for (int o = 0; o < 4; o++)
          for (int st = 0; st < 2; st++)
            for (int u = 0; u < 2; u++) begin
              logic [31:0] ea, sd, b, w, src, mask, eexp, lexp, v;
              logic [15:0] d;
              logic mis;
              logic [3:0] bex;
              ea  = 32'h0000_1000 + 32'(o) + (di == 1 ? 32'h0002_0000 : 0);
              d   = (di == 0) ? 16'h0010 : 16'hFFF8;
              sd  = {{16{d[15]}}, d};
              b   = ea - sd;
              w   = (di == 0) ? 32'hABCD1234 : 32'h7F8011FE;
              src = (u == 0) ? 32'hDEADBEEF : 32'h13572468;
              mis = (sz == 1 && o[0]) || (sz >= 2 && o != 0);
              if (sz == 0) bex = 4'b1000 >> o;
              else if (sz == 1) bex = (o == 2) ? 4'b0011 : 4'b1100;
              else bex = 4'b1111;
              req(st[0], sz[1:0], u[0], b, d, src);
              mem_rdata = w;
              #1;
              chk("R1 addr", mem_addr, ea & 32'hFFFF_FFFC);
              chk("R2 R3 misalign", {31'b0, misalign}, {31'b0, mis});
              chk("R4 R10 wr", {31'b0, mem_wr}, {31'b0, st == 1 && !mis});
              chk("R10 rd", {30'b0, mem_rd, ld_valid}, {30'b0, {2{st == 0 && !mis}}});
              chk("R3 R4 R10 be", {28'b0, mem_be}, {28'b0, (st == 1 && !mis) ? bex : 4'b0});
              if (st == 1 && !mis) begin
                if (sz == 0) begin
                  mask = 32'hFF << (8 * (3 - o));
                  eexp = (w & ~mask) | ((src & 32'hFF) << (8 * (3 - o)));
                end else if (sz == 1) begin
                  mask = 32'hFFFF << (8 * (2 - o));
                  eexp = (w & ~mask) | ((src & 32'hFFFF) << (8 * (2 - o)));
                end else eexp = src;
                chk("R5 merged", merge(w, mem_wdata, mem_be), eexp);
              end
              if (st == 0) begin
                if (mis) lexp = 0;
                else if (sz == 0) begin
                  v = (w >> (8 * (3 - o))) & 32'hFF;
                  lexp = (u == 0 && v[7]) ? (v | 32'hFFFF_FF00) : v;
                end else if (sz == 1) begin
                  v = (w >> (8 * (2 - o))) & 32'hFFFF;
                  lexp = (u == 0 && v[15]) ? (v | 32'hFFFF_0000) : v;
                end else lexp = w;
                chk("R6 R7 ld_data", ld_data, lexp);
              end
              @(negedge clk);
              chk("R3 R9 one-cycle idle", {28'b0, mem_rd, mem_wr, misalign, ld_valid}, 0);
              chk("R9 be/ld", {28'b0, mem_be} | ld_data, 0);
            end

    // worked examples from the big-endian word 0xABCD1234 at 0x1000
    req(0, 0, 0, 32'h1000, 16'h0001, 0); mem_rdata = 32'hABCD1234; #1;
    chk("R7 signed byte", ld_data, 32'hFFFFFFCD);
    @(negedge clk);
    req(0, 0, 1, 32'h1000, 16'h0000, 0); mem_rdata = 32'hABCD1234; #1;
    chk("R7 unsigned byte", ld_data, 32'h000000AB);
    @(negedge clk);
    req(1, 1, 0, 32'h1000, 16'h0000, 32'hDEADBEEF); #1;
    chk("R5 halfword store", merge(32'hABCD1234, mem_wdata, mem_be), 32'hBEEF1234);
    @(negedge clk);
    req(1, 0, 0, 32'h1000, 16'h0003, 32'hDEADBEEF); #1;
    chk("R5 byte store", merge(32'hABCD1234, mem_wdata, mem_be), 32'hABCD12EF);
    @(negedge clk);
    req(1, 2, 0, 32'h0000_0040, 16'h0010, 32'h000F4240); #1;
    chk("R1 R4 word addr", mem_addr, 32'h50);
    chk("R5 word order", merge(32'h0, mem_wdata, mem_be), 32'h000F4240);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule